// File: doc/BRIEF.md
# Address-Aliased Atomic Word Memory

This block is an on-chip word memory with one request port and one response port. It has two storage channels. The operation to apply is not carried on an opcode bus. It is chosen by the high address bits. Each channel's storage is visible through four address windows. One window serves plain read, write and swap. The other three apply bit set, bit clear and add to the addressed word. A test flag on the request makes an update return the word as it was before the update. Increment and decrement are both adds: decrement uses the two's-complement operand.

Each accepted request takes two cycles. In the cycle after acceptance, the old word is on the response port and the new word is committed at the end of that cycle. The ready output is low during that cycle, so no other request can slip between the read and the write of an update. That makes every read-modify-write atomic. An address outside both channel regions, or beyond the parameterised channel depth, returns zero with an error flag and leaves the memory unchanged.

Top module: `atomic_sram_unit`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid is 0.
- R2: An address decodes as follows. Bits 31:29 must be 3'b100. Bit 28 picks channel 0 (0x8000_0000) or channel 1 (0x9000_0000). Bits 27:26 pick the window: 0 is read/write/swap, 1 is bit set, 2 is bit clear, 3 is add. Bits 25:2 give the word index. Bits 1:0 are ignored.
- R3: In window 0 with req_write=1 and req_test=0, the operand is stored and the response data is 0. With req_write=0, the stored word is returned and nothing is changed, whatever the value of req_test.
- R4: In window 0 with req_write=1 and req_test=1 (swap), the operand is stored and the previous word is returned.
- R5: Window 1 stores old OR operand.
- R6: Window 2 stores old AND NOT operand.
- R7: Window 3 stores (old + operand) mod 2^32. An operand of 0xFFFF_FFFF therefore decrements.
- R8: All four windows of a channel address the same words. The same index in channel 0 and in channel 1 holds independent words.
- R9: rsp_valid is 1 exactly in the cycle after acceptance (req_valid and req_ready both high at a clock edge). req_ready is 0 in that cycle and 1 again in the cycle after it.
- R10: A request held valid while req_ready is 0 is not accepted. Once it is accepted, it sees the word already updated by the previous request.
- R11: An address with bits 31:29 other than 3'b100, or with a word index of WORDS_PER_CH or more, gives rsp_err=1 and rsp_rdata=0, and no word is changed.
- R12: For update windows 1 to 3, the response data is the old word when req_test=1 and 0 when req_test=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_addr | input | 32 | Byte address; selects channel, window and word |
| req_write | input | 1 | Window 0 only: 1 writes or swaps, 0 reads |
| req_test | input | 1 | Return the pre-update word |
| req_wdata | input | 32 | Write data or operation operand |
| rsp_valid | output | 1 | Response present; one cycle after acceptance |
| rsp_err | output | 1 | Address was outside the mapped storage |
| rsp_rdata | output | 32 | Returned word (old value, or 0) |

## Verification
The two functions that can fall in the same cycle are the commit of one request's read-modify-write and the arrival of the next request. The bench provokes this by raising a second add to the same word in the very cycle the first add's response is shown, and holding it valid while ready is low. It judges the result by two things. The held request must not be accepted during the commit cycle. Once it is accepted, its returned old word must already contain the first add, and a final read must show both sums.

// File: rtl/atomic_sram_pkg.sv
`timescale 1ns/1ps
package atomic_sram_pkg;
   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 32;
   localparam int CH_COUNT = 2;
   localparam int WORD_FW  = 24;   // address bits 25:2

   typedef enum logic [1:0] {
      WIN_RWS = 2'd0,
      WIN_SET = 2'd1,
      WIN_CLR = 2'd2,
      WIN_ADD = 2'd3
   } win_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } st_e;

   typedef struct packed {
      logic               err;
      logic               ch;
      win_e               win;
      logic [WORD_FW-1:0] word;
   } dec_t;
endpackage

// File: rtl/atomic_addr_decode.sv
`timescale 1ns/1ps
module atomic_addr_decode
   import atomic_sram_pkg::*;
#(
   parameter int          WORDS_PER_CH = 256,
   parameter logic [2:0]  REGION_TAG   = 3'b100
)(
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);
   logic unused_lowbits;
   assign unused_lowbits = ^addr[1:0];

   logic in_region;
   logic in_depth;

   assign in_region = (addr[31:29] == REGION_TAG);
   assign in_depth  = ({8'd0, addr[25:2]} < WORDS_PER_CH);

   always_comb begin
      dec.ch   = addr[28];
      dec.win  = win_e'(addr[27:26]);
      dec.word = addr[25:2];
      dec.err  = !(in_region && in_depth);
   end
endmodule

// File: rtl/atomic_rmw_alu.sv
`timescale 1ns/1ps
module atomic_rmw_alu
   import atomic_sram_pkg::*;
(
   input  win_e              win,
   input  logic              is_write,
   input  logic              is_test,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] operand,
   output logic              upd_en,
   output logic [DATA_W-1:0] new_val,
   output logic [DATA_W-1:0] ret_val
);
   always_comb begin
      upd_en  = 1'b0;
      new_val = old_val;
      ret_val = '0;
      unique case (win)
         WIN_RWS: begin
            if (is_write) begin
               upd_en  = 1'b1;
               new_val = operand;
               ret_val = is_test ? old_val : '0;
            end else begin
               ret_val = old_val;
            end
         end
         WIN_SET: begin
            upd_en  = 1'b1;
            new_val = old_val | operand;
            ret_val = is_test ? old_val : '0;
         end
         WIN_CLR: begin
            upd_en  = 1'b1;
            new_val = old_val & ~operand;
            ret_val = is_test ? old_val : '0;
         end
         default: begin
            upd_en  = 1'b1;
            new_val = old_val + operand;
            ret_val = is_test ? old_val : '0;
         end
      endcase
   end
endmodule

// File: rtl/atomic_word_bank.sv
`timescale 1ns/1ps
module atomic_word_bank #(
   parameter int WORDS = 256,
   parameter int DW    = 32,
   localparam int IW   = $clog2(WORDS)
)(
   input  logic          clk,
   input  logic          rd_en,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data
);
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
      if (rd_en) rd_data <= mem[rd_idx];
   end
endmodule

// File: rtl/atomic_sram_unit.sv
`timescale 1ns/1ps
module atomic_sram_unit
   import atomic_sram_pkg::*;
#(
   parameter int WORDS_PER_CH = 256
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_test,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata
);
   localparam int IW = $clog2(WORDS_PER_CH);

   if (WORDS_PER_CH < 2 || WORDS_PER_CH > 32768) begin : g_bad_depth
      $error("WORDS_PER_CH must be 2..32768 (128 kB per channel)");
   end
   if ((1 << IW) != WORDS_PER_CH) begin : g_bad_pow2
      $error("WORDS_PER_CH must be a power of two");
   end

   st_e  state;
   logic accept;
   dec_t dec;

   dec_t              lat_dec;
   logic              lat_write;
   logic              lat_test;
   logic [DATA_W-1:0] lat_operand;

   logic [DATA_W-1:0] bank_rd [CH_COUNT];
   logic [CH_COUNT-1:0] bank_we;
   logic [CH_COUNT-1:0] bank_re;
   logic [DATA_W-1:0] old_val;
   logic              upd_en;
   logic [DATA_W-1:0] new_val;
   logic [DATA_W-1:0] ret_val;

   logic unused_wordhi;
   assign unused_wordhi = ^{dec.word[WORD_FW-1:IW], lat_dec.word[WORD_FW-1:IW]};

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   atomic_addr_decode #(.WORDS_PER_CH(WORDS_PER_CH)) u_dec (
      .addr (req_addr),
      .dec  (dec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         lat_dec     <= '0;
         lat_write   <= 1'b0;
         lat_test    <= 1'b0;
         lat_operand <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) state <= ST_BUSY;
            default: state <= ST_IDLE;
         endcase
         if (accept) begin
            lat_dec     <= dec;
            lat_write   <= req_write;
            lat_test    <= req_test;
            lat_operand <= req_wdata;
         end
      end
   end

   for (genvar g = 0; g < CH_COUNT; g++) begin : g_bank
      assign bank_re[g] = accept && !dec.err && (dec.ch == 1'(g));
      assign bank_we[g] = (state == ST_BUSY) && upd_en && !lat_dec.err
                          && (lat_dec.ch == 1'(g));
      atomic_word_bank #(.WORDS(WORDS_PER_CH), .DW(DATA_W)) u_bank (
         .clk     (clk),
         .rd_en   (bank_re[g]),
         .rd_idx  (dec.word[IW-1:0]),
         .rd_data (bank_rd[g]),
         .wr_en   (bank_we[g]),
         .wr_idx  (lat_dec.word[IW-1:0]),
         .wr_data (new_val)
      );
   end

   assign old_val = bank_rd[lat_dec.ch];

   atomic_rmw_alu u_alu (
      .win      (lat_dec.win),
      .is_write (lat_write),
      .is_test  (lat_test),
      .old_val  (old_val),
      .operand  (lat_operand),
      .upd_en   (upd_en),
      .new_val  (new_val),
      .ret_val  (ret_val)
   );

   assign rsp_valid = (state == ST_BUSY);
   assign rsp_err   = lat_dec.err;
   assign rsp_rdata = lat_dec.err ? '0 : ret_val;

   // R9: an accepted request owns the next cycle and is answered in it
   p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!req_ready && rsp_valid));

   p_rsp_needs_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(accept));

   // R10: after the commit cycle the port reopens
   p_ready_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   // R10: no bank is read while an update is pending
   p_no_read_in_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (bank_re == '0));

   // R8: at most one channel is written per cycle
   p_one_bank_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));

   // R11: an errored request returns zero and writes nothing
   p_err_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_rdata == '0 && bank_we == '0));
endmodule

// File: tb/atomic_sram_unit_bench.sv
`timescale 1ns/1ps
module atomic_sram_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_addr;
   logic        req_write;
   logic        req_test;
   logic [31:0] req_wdata;
   logic        rsp_valid;
   logic        rsp_err;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   atomic_sram_unit #(.WORDS_PER_CH(256)) u_atomic_sram_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_test(req_test),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata)
   );

   function automatic logic [31:0] mk(input int ch, input int win, input int word);
      return 32'h8000_0000 | (32'(ch) << 28) | (32'(win) << 26) | (32'(word) << 2);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one request; returns the response seen in the cycle after acceptance
   task automatic xfer(input logic [31:0] a, input bit wr, input bit tst,
                       input logic [31:0] d, output logic [31:0] rd,
                       output bit er);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_test = tst;
      req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid === 1'b1, "R9 rsp_valid after accept", 32'(rsp_valid), 1);
      rd = rsp_rdata;
      er = rsp_err;
   endtask

   task automatic t_reset();
      check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
      check(rsp_valid === 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);
   endtask

   task automatic t_write_read();
      logic [31:0] r; bit e;
      xfer(mk(0,0,5), 1, 0, 32'hA5A5_1234, r, e);
      check(r == 0 && !e, "R3 write returns zero", r, 0);
      xfer(mk(0,0,5), 0, 0, 0, r, e);
      check(r == 32'hA5A5_1234, "R3 read back", r, 32'hA5A5_1234);
      xfer(mk(0,0,5) | 32'h3, 0, 1, 32'hFFFF_FFFF, r, e);
      check(r == 32'hA5A5_1234, "R2 low bits ignored, R3 test ignored on read", r, 32'hA5A5_1234);
   endtask

   task automatic t_swap();
      logic [31:0] r; bit e;
      xfer(mk(0,0,5), 1, 1, 32'h1111_2222, r, e);
      check(r == 32'hA5A5_1234, "R4 swap returns old", r, 32'hA5A5_1234);
      xfer(mk(0,0,5), 0, 0, 0, r, e);
      check(r == 32'h1111_2222, "R4 swap stored operand", r, 32'h1111_2222);
   endtask

   task automatic t_set();
      logic [31:0] r; bit e;
      xfer(mk(0,0,7), 1, 0, 32'h0000_00F0, r, e);
      xfer(mk(0,1,7), 0, 0, 32'h0F00_000F, r, e);
      check(r == 0, "R12 set without test returns zero", r, 0);
      xfer(mk(0,1,7), 0, 1, 32'h0000_0100, r, e);
      check(r == 32'h0F00_00FF, "R5 test-and-set returns old", r, 32'h0F00_00FF);
      xfer(mk(0,0,7), 0, 0, 0, r, e);
      check(r == 32'h0F00_01FF, "R5 set result", r, 32'h0F00_01FF);
   endtask

   task automatic t_clear();
      logic [31:0] r; bit e;
      xfer(mk(0,2,7), 0, 1, 32'h0F00_0000, r, e);
      check(r == 32'h0F00_01FF, "R6 test-and-clear returns old", r, 32'h0F00_01FF);
      xfer(mk(0,2,7), 0, 0, 32'h0000_000F, r, e);
      check(r == 0, "R12 clear without test returns zero", r, 0);
      xfer(mk(0,0,7), 0, 0, 0, r, e);
      check(r == 32'h0000_01F0, "R6 clear result", r, 32'h0000_01F0);
   endtask

   task automatic t_add();
      logic [31:0] r; bit e;
      xfer(mk(0,0,9), 1, 0, 32'hFFFF_FFFE, r, e);
      xfer(mk(0,3,9), 0, 1, 32'd3, r, e);
      check(r == 32'hFFFF_FFFE, "R7 test-and-add returns old", r, 32'hFFFF_FFFE);
      xfer(mk(0,0,9), 0, 0, 0, r, e);
      check(r == 32'd1, "R7 add wraps", r, 1);
      xfer(mk(0,3,9), 0, 0, 32'hFFFF_FFFF, r, e);
      xfer(mk(0,0,9), 0, 0, 0, r, e);
      check(r == 32'd0, "R7 decrement by adding all-ones", r, 0);
   endtask

   task automatic t_alias();
      logic [31:0] r; bit e;
      xfer(mk(1,0,5), 1, 0, 32'h0000_CAFE, r, e);
      xfer(mk(0,0,5), 0, 0, 0, r, e);
      check(r == 32'h1111_2222, "R8 channel 0 untouched by channel 1", r, 32'h1111_2222);
      xfer(mk(1,1,5), 0, 1, 32'h0, r, e);
      check(r == 32'h0000_CAFE, "R8 set window aliases channel 1 word", r, 32'h0000_CAFE);
      xfer(mk(1,3,5), 0, 1, 32'h0, r, e);
      check(r == 32'h0000_CAFE, "R8 add window aliases same word", r, 32'h0000_CAFE);
   endtask

   task automatic t_timing();
      @(negedge clk);
      req_valid = 1'b1; req_addr = mk(0,0,5); req_write = 1'b0;
      req_test = 1'b0; req_wdata = 0;
      check(req_ready === 1'b1, "R9 ready before accept", 32'(req_ready), 1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready === 1'b0, "R9 ready low in response cycle", 32'(req_ready), 0);
      check(rsp_valid === 1'b1, "R9 response one cycle after accept", 32'(rsp_valid), 1);
      @(negedge clk);
      check(req_ready === 1'b1, "R9 ready back", 32'(req_ready), 1);
      check(rsp_valid === 1'b0, "R9 response lasts one cycle", 32'(rsp_valid), 0);
   endtask

   task automatic t_contention();
      logic [31:0] r; bit e;
      xfer(mk(0,0,12), 1, 0, 32'd10, r, e);
      @(negedge clk);
      req_valid = 1'b1; req_addr = mk(0,3,12); req_write = 1'b0;
      req_test = 1'b1; req_wdata = 32'd5;
      @(posedge clk);
      @(negedge clk);
      check(rsp_rdata == 32'd10, "R10 first add returns old", rsp_rdata, 10);
      // second add raised during the first add's commit cycle
      req_addr = mk(0,3,12); req_wdata = 32'd7;
      check(req_ready === 1'b0, "R10 held request blocked", 32'(req_ready), 0);
      @(posedge clk);
      @(negedge clk);
      check(req_ready === 1'b1 && rsp_valid === 1'b0, "R10 not accepted during commit",
            32'(rsp_valid), 0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid === 1'b1 && rsp_rdata == 32'd15, "R10 second add sees first",
            rsp_rdata, 15);
      xfer(mk(0,0,12), 0, 0, 0, r, e);
      check(r == 32'd22, "R10 both adds committed", r, 22);
   endtask

   task automatic t_error();
      logic [31:0] r; bit e;
      xfer(mk(0,0,44), 1, 0, 32'h0000_0044, r, e);
      xfer(32'h7000_0000, 1, 1, 32'hDEAD_BEEF, r, e);
      check(e && r == 0, "R11 below region errors", r, 0);
      xfer(32'hA000_0014, 0, 0, 0, r, e);
      check(e && r == 0, "R11 above region errors", r, 0);
      xfer(mk(0,0,300), 1, 0, 32'hDEAD_BEEF, r, e);
      check(e && r == 0, "R11 beyond depth errors", r, 0);
      xfer(mk(0,0,44), 0, 0, 0, r, e);
      check(!e && r == 32'h0000_0044, "R11 memory unchanged after error", r, 32'h44);
      xfer(mk(0,0,5), 0, 0, 0, r, e);
      check(!e && r == 32'h1111_2222, "R11 word 5 unchanged after error", r, 32'h1111_2222);
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
      req_test = 1'b0; req_wdata = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_read();
      t_swap();
      t_set();
      t_clear();
      t_add();
      t_alias();
      t_timing();
      t_contention();
      t_error();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule